// File: doc/BRIEF.md
# Odd-Ratio Half-Duty Clock Divider

This block takes an input clock and produces an output clock whose period is a fixed odd number of input periods, `DIV_N`, with the output high for exactly half of that period. Half of an odd number of input periods falls midway through an input cycle. Plain rising-edge logic cannot place an edge there, so the block also uses one flop clocked on the falling input edge.

A modulo-`DIV_N` phase counter runs on the rising edge. From its count, a registered lead signal is raised for `(DIV_N-1)/2` input cycles in each output period. A falling-edge flop carries a copy of that lead signal, delayed by half an input cycle. The output is the OR of the two, so it stays high for `DIV_N` input half-periods and low for the same span.

The ratio is fixed when the design is elaborated. An even ratio, or a ratio below 3, stops elaboration. An active-low asynchronous reset clears all state, and the output stays low while reset is held.

Top module: `odd_duty_div`

## Requirements
- R1: While `rstN` is low, `clkOut` is 0, whatever the input clock is doing.
- R2: Once the output is running, every output period lasts exactly `DIV_N` input-clock periods.
- R3: In every output period, `clkOut` is high for exactly `DIV_N` input half-periods and low for exactly `DIV_N` input half-periods.
- R4: `clkOut` goes high just after a rising input edge and goes low just after a falling input edge.
- R5: After reset is released while `clkIn` is low, `clkOut` stays low through the first `DIV_N-1` rising input edges and first goes high on rising edge number `DIV_N`.
- R6: The internal phase count starts at 0 after reset. It rises by one on each rising input edge and wraps from `DIV_N-1` back to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| clkOut | output | 1 | Divided clock with 50% duty, period `DIV_N` input periods |

## Verification
Three copies with ratios 3, 5 and 7 run on a shared input clock. The bench samples each output once in every input half-period, midway between edges. It compares every sample with an arithmetic model of the high and low windows, and that model places the first rise at rising edge `DIV_N`. The first sweep after power-up shows whether the counter start point and the reset release are placed correctly. A second reset, asserted partway through a run, shows that the output is forced low at once and that the same start-up sequence follows again. Comparing the sample in the high half of each input cycle with the sample in the low half separates correct half-cycle placement of the output edges from an output that has the right period but the wrong duty or phase.

// File: rtl/odd_duty_div_pkg.sv
package odd_duty_div_pkg;

  // Strobes from the phase control to the lead/lag datapath
  typedef struct packed {
    logic setLead;   // phase is at its last value: raise lead on next rising edge
    logic clrLead;   // lead has been high for its full span: drop it on next rising edge
  } leadStrobe_t;

endpackage

// File: rtl/odd_duty_ctrl.sv
module odd_duty_ctrl
  import odd_duty_div_pkg::*;
#(
  parameter int DIV_N = 3,
  localparam int CNT_W = $clog2(DIV_N)
) (
  input  logic             clkIn,
  input  logic             rstN,
  output logic [CNT_W-1:0] phaseCnt,
  output leadStrobe_t      strobe
);

  localparam int HALF_CYC = (DIV_N - 1) / 2;
  localparam logic [CNT_W-1:0] LAST_PHASE = CNT_W'(DIV_N - 1);
  localparam logic [CNT_W-1:0] CLR_PHASE  = CNT_W'(HALF_CYC - 1);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (phaseCnt == LAST_PHASE) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.setLead = (phaseCnt == LAST_PHASE);
    strobe.clrLead = (phaseCnt == CLR_PHASE);
  end

endmodule

// File: rtl/odd_duty_path.sv
module odd_duty_path
  import odd_duty_div_pkg::*;
(
  input  logic        clkIn,
  input  logic        rstN,
  input  leadStrobe_t strobe,
  output logic        leadQ,
  output logic        lagQ,
  output logic        clkOut
);

  // Lead: registered on the rising edge, so it never glitches
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      leadQ <= 1'b0;
    end else if (strobe.setLead) begin
      leadQ <= 1'b1;
    end else if (strobe.clrLead) begin
      leadQ <= 1'b0;
    end
  end

  // Lag: the lead, half an input cycle later
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) begin
      lagQ <= 1'b0;
    end else begin
      lagQ <= leadQ;
    end
  end

  assign clkOut = leadQ | lagQ;

endmodule

// File: rtl/odd_duty_div.sv
module odd_duty_div
  import odd_duty_div_pkg::*;
#(
  parameter int DIV_N = 3
) (
  input  logic clkIn,
  input  logic rstN,
  output logic clkOut
);

  localparam int CNT_W = $clog2(DIV_N);

  generate
    if ((DIV_N % 2) == 0 || DIV_N < 3) begin : g_badRatio
      $error("odd_duty_div: DIV_N must be odd and at least 3");
    end
  endgenerate

  logic [CNT_W-1:0] phaseCnt;
  leadStrobe_t      strobe;
  logic             leadQ;
  logic             lagQ;

  odd_duty_ctrl #(.DIV_N(DIV_N)) u_ctrl (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .phaseCnt(phaseCnt),
    .strobe  (strobe)
  );

  odd_duty_path u_path (
    .clkIn (clkIn),
    .rstN  (rstN),
    .strobe(strobe),
    .leadQ (leadQ),
    .lagQ  (lagQ),
    .clkOut(clkOut)
  );

endmodule

// File: rtl/odd_duty_div_chk.sv
module odd_duty_div_chk #(
  parameter int DIV_N = 3,
  localparam int CNT_W = $clog2(DIV_N)
) (
  input logic             clkIn,
  input logic             rstN,
  input logic             clkOut,
  input logic [CNT_W-1:0] phaseCnt,
  input logic             leadQ,
  input logic             lagQ
);

  localparam int HALF_CYC = (DIV_N - 1) / 2;

  // R1: output low while reset is held
  p_low_in_reset_r1: assert property (@(posedge clkIn) !rstN |-> !clkOut)
    else $error("p_low_in_reset_r1");

  // R6: phase count stays in range
  p_cnt_range_r6: assert property (@(posedge clkIn) disable iff (!rstN)
    phaseCnt < CNT_W'(DIV_N))
    else $error("p_cnt_range_r6");

  // R6: count wraps from the last phase to zero
  p_cnt_wrap_r6: assert property (@(posedge clkIn) disable iff (!rstN)
    (phaseCnt == CNT_W'(DIV_N - 1)) |=> (phaseCnt == '0))
    else $error("p_cnt_wrap_r6");

  // R6: count steps by one below the last phase
  p_cnt_step_r6: assert property (@(posedge clkIn) disable iff (!rstN)
    (phaseCnt != CNT_W'(DIV_N - 1)) |=> (phaseCnt == CNT_W'($past(phaseCnt) + 1'b1)))
    else $error("p_cnt_step_r6");

  // R2: the lead rises only at the start of a period
  p_lead_rise_r2: assert property (@(posedge clkIn) disable iff (!rstN)
    $rose(leadQ) |-> (phaseCnt == '0))
    else $error("p_lead_rise_r2");

  // R3: the lead falls after (DIV_N-1)/2 cycles
  p_lead_fall_r3: assert property (@(posedge clkIn) disable iff (!rstN)
    $fell(leadQ) |-> (phaseCnt == CNT_W'(HALF_CYC)))
    else $error("p_lead_fall_r3");

  // R4: the lag copies the lead half a cycle later
  p_lag_follow_r4: assert property (@(negedge clkIn) disable iff (!rstN)
    lagQ == $past(leadQ))
    else $error("p_lag_follow_r4");

endmodule

bind odd_duty_div odd_duty_div_chk #(.DIV_N(DIV_N)) u_chk (
  .clkIn   (clkIn),
  .rstN    (rstN),
  .clkOut  (clkOut),
  .phaseCnt(phaseCnt),
  .leadQ   (leadQ),
  .lagQ    (lagQ)
);

// File: tb/odd_duty_div_bench.sv
`timescale 1ns/1ps
module odd_duty_div_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic out3, out5, out7;
  int checkCnt = 0;
  int failCnt = 0;

  always #5 clk = ~clk;   // 100 MHz

  odd_duty_div #(.DIV_N(3)) u_odd_duty_div (.clkIn(clk), .rstN(rstN), .clkOut(out3));
  odd_duty_div #(.DIV_N(5)) u_div5 (.clkIn(clk), .rstN(rstN), .clkOut(out5));
  odd_duty_div #(.DIV_N(7)) u_div7 (.clkIn(clk), .rstN(rstN), .clkOut(out7));

  // Expected level at half-period index h, counted from the first rise
  function automatic bit expHigh(int h, int n);
    return (h >= 0) && ((h % (2 * n)) < n);
  endfunction

  task automatic check(bit got, bit exp, string req, int n, int e);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s N=%0d edge=%0d actual=%0b expected=%0b", req, n, e, got, exp);
    end
  endtask

  task automatic checkAll(int h, int e);
    // R5 and R6 cover the start-up edges; R2, R3 and R4 cover the steady run
    check(out3, expHigh(h, 3), (e <= 3) ? "R5/R6" : "R2/R3/R4", 3, e);
    check(out5, expHigh(h, 5), (e <= 5) ? "R5/R6" : "R2/R3/R4", 5, e);
    check(out7, expHigh(h, 7), (e <= 7) ? "R5/R6" : "R2/R3/R4", 7, e);
  endtask

  // Sample after every rising edge (clock high) and every falling edge (clock low)
  task automatic sweep(int edges);
    for (int e = 1; e <= edges; e++) begin
      @(posedge clk); #2;
      check(out3, expHigh(2 * (e - 3), 3), (e <= 3) ? "R5" : "R2/R4", 3, e);
      check(out5, expHigh(2 * (e - 5), 5), (e <= 5) ? "R5" : "R2/R4", 5, e);
      check(out7, expHigh(2 * (e - 7), 7), (e <= 7) ? "R5" : "R2/R4", 7, e);
      @(negedge clk); #2;
      check(out3, expHigh(2 * (e - 3) + 1, 3), (e <= 3) ? "R6" : "R3/R4", 3, e);
      check(out5, expHigh(2 * (e - 5) + 1, 5), (e <= 5) ? "R6" : "R3/R4", 5, e);
      check(out7, expHigh(2 * (e - 7) + 1, 7), (e <= 7) ? "R6" : "R3/R4", 7, e);
    end
  endtask

  task automatic checkReset(string req);
    check(out3, 1'b0, req, 3, 0);
    check(out5, 1'b0, req, 5, 0);
    check(out7, 1'b0, req, 7, 0);
  endtask

  initial begin : watchdog
    #200000;
    failCnt++;
    checkCnt++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    #7  checkReset("R1");      // clock high, reset held
    #5  checkReset("R1");      // clock low, reset held
    #10 rstN = 1'b1;           // t=22, clock low
    sweep(60);
    // Reset partway through a run, while the clock is low
    #1 rstN = 1'b0;
    #1 checkReset("R1");
    @(posedge clk); #2 checkReset("R1");
    @(negedge clk); #2 rstN = 1'b1;
    sweep(50);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule